// File: doc/BRIEF.md
# Node Buffer Ownership Controller

This block decides who owns each memory buffer of a processing node in which an input device, a processor and an output device run as a three-stage pipeline. The node has two separate pools: input buffers that the input device fills and the processor reads, and output buffers that the processor writes and the output device sends. Each pool has its own size parameter. The block only moves ownership between the three agents. It does not copy or compute data. Processing is out-of-place: each job reads one input buffer and writes a different output buffer, so no data is ever copied between them.

Each agent gets a one-cycle start pulse that names the buffer or buffers it may use. It answers with a done pulse when the work is finished. An input buffer goes from free to filling, then to ready (waiting for the processor), then to in-work, and then back to free. An output buffer goes from free to being written, then to pending, then to sending, and then back to free. Ready input buffers and pending output buffers are each held in an index queue, so blocks leave the node in the order they arrived. The block reports how many buffers of each pool are in each state. It flags a lost block when a new block arrives and cannot be placed in a buffer.

Top module: `node_buf_ctrl`

## Requirements
- R1: During and right after reset, all buffers of both pools are free. The free counts equal IN_BUFS and OUT_BUFS. All other counts are zero, and no start pulse or overflow is asserted.
- R2: A new-block request that arrives while the input device is idle and at least one input buffer is free produces, one cycle later, a single-cycle input start pulse. The pulse carries the lowest-numbered free input buffer, and that buffer is then counted as filling.
- R3: A new-block request that arrives while a fill is in progress, or while no input buffer is free, produces a single-cycle overflow pulse one cycle later. It gives no input start pulse and leaves all counts unchanged.
- R4: An input done pulse during a fill turns the filled buffer into a ready buffer. It is appended to the back of the ready queue.
- R5: The processor is started only when it is idle, at least one ready input buffer exists and at least one free output buffer exists. The start pulse carries the oldest ready input buffer and the lowest-numbered free output buffer. In any other case the processor is not started.
- R6: A processor done pulse returns its input buffer to free at once and moves its output buffer to pending, at the back of the pending queue.
- R7: The output device, when idle, is started on the oldest pending output buffer. An output done pulse returns that buffer to free, and only then can it be given to the processor again.
- R8: A done pulse from an agent that holds no buffer is ignored and changes no state.
- R9: In each pool, the four state counts always add up to the pool size.
- R10: With two buffers per pool and a steady workload (block period 6 cycles, fill 4, process 5, send 4), filling, processing and sending are all active in the same cycle, and no block is lost.
- R11: Every start pulse lasts exactly one cycle, and each agent works on at most one job at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | A new block is arriving at the input device |
| in_done | input | 1 | Input device finished filling its buffer |
| proc_done | input | 1 | Processor finished its job |
| out_done | input | 1 | Output device finished sending its buffer |
| in_start | output | 1 | Input device may fill the buffer in in_start_idx |
| in_start_idx | output | IIW = max(1, clog2(IN_BUFS)) | Input buffer granted to the input device |
| proc_start | output | 1 | Processor may start a job |
| proc_in_idx | output | IIW | Input buffer to read |
| proc_out_idx | output | OIW = max(1, clog2(OUT_BUFS)) | Output buffer to write |
| out_start | output | 1 | Output device may send the buffer in out_start_idx |
| out_start_idx | output | OIW | Output buffer granted to the output device |
| overflow | output | 1 | A block was lost because it could not be placed |
| in_free_cnt | output | clog2(IN_BUFS+1) | Free input buffers |
| in_fill_cnt | output | clog2(IN_BUFS+1) | Input buffers being filled |
| in_ready_cnt | output | clog2(IN_BUFS+1) | Input buffers waiting for the processor |
| in_work_cnt | output | clog2(IN_BUFS+1) | Input buffers being read by the processor |
| out_free_cnt | output | clog2(OUT_BUFS+1) | Free output buffers |
| out_write_cnt | output | clog2(OUT_BUFS+1) | Output buffers being written |
| out_pend_cnt | output | clog2(OUT_BUFS+1) | Output buffers waiting to be sent |
| out_send_cnt | output | clog2(OUT_BUFS+1) | Output buffers being sent |

## Verification
Some checks run on every cycle: the state counts of each pool always add up to the pool size, and every start pulse lasts one cycle. A request during a fill always flags overflow. An idle processor with a ready input buffer and a free output buffer is always started on the next cycle. The index queues are never pushed when full or popped when empty. Other behaviour can only be shown by the bench scenarios: grants go oldest-first, a stalled output device pushes back until the node loses a block, stray done pulses have no effect, and a steady two-buffer workload overlaps all three stages.

// File: rtl/nbc_pkg.sv
package nbc_pkg;
  typedef enum logic [1:0] {IS_FREE = 2'd0, IS_FILL = 2'd1, IS_READY = 2'd2, IS_WORK = 2'd3} in_st_e;
  typedef enum logic [1:0] {OS_FREE = 2'd0, OS_WRITE = 2'd1, OS_PEND = 2'd2, OS_SEND = 2'd3} out_st_e;
endpackage

// File: rtl/nbc_first_free.sv
module nbc_first_free #(
  parameter int N = 2,
  parameter int W = 1
) (
  input  logic [N-1:0] mask,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/nbc_idx_fifo.sv
module nbc_idx_fifo #(
  parameter int DEPTH = 2,
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_idx,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      if (push && !pop) cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  // R4: a queue of buffer indices can never hold more than the pool size
  assert_no_overrun_R4: assert property (@(posedge clk) disable iff (rst) push |-> (!full || pop));
  // R5: the processor only takes a ready buffer that exists
  assert_no_underrun_R5: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/node_buf_ctrl.sv
module node_buf_ctrl
  import nbc_pkg::*;
#(
  parameter int IN_BUFS = 2,
  parameter int OUT_BUFS = 2,
  localparam int IIW = (IN_BUFS > 1) ? $clog2(IN_BUFS) : 1,
  localparam int OIW = (OUT_BUFS > 1) ? $clog2(OUT_BUFS) : 1,
  localparam int ICW = $clog2(IN_BUFS + 1),
  localparam int OCW = $clog2(OUT_BUFS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_req,
  input  logic           in_done,
  input  logic           proc_done,
  input  logic           out_done,
  output logic           in_start,
  output logic [IIW-1:0] in_start_idx,
  output logic           proc_start,
  output logic [IIW-1:0] proc_in_idx,
  output logic [OIW-1:0] proc_out_idx,
  output logic           out_start,
  output logic [OIW-1:0] out_start_idx,
  output logic           overflow,
  output logic [ICW-1:0] in_free_cnt,
  output logic [ICW-1:0] in_fill_cnt,
  output logic [ICW-1:0] in_ready_cnt,
  output logic [ICW-1:0] in_work_cnt,
  output logic [OCW-1:0] out_free_cnt,
  output logic [OCW-1:0] out_write_cnt,
  output logic [OCW-1:0] out_pend_cnt,
  output logic [OCW-1:0] out_send_cnt
);
  in_st_e  ist [IN_BUFS];
  out_st_e ost [OUT_BUFS];

  logic           in_busy, p_busy, o_busy;
  logic [IIW-1:0] in_cur, p_in;
  logic [OIW-1:0] p_out, o_cur;

  logic [IN_BUFS-1:0]  in_free_mask;
  logic [OUT_BUFS-1:0] out_free_mask;
  logic                in_has_free, out_has_free;
  logic [IIW-1:0]      in_pick, rdy_head;
  logic [OIW-1:0]      out_pick, pend_head;
  logic                rdy_empty, pend_empty;

  logic in_go, in_fin, proc_go, proc_fin, out_go, out_fin;

  always_comb begin
    for (int i = 0; i < IN_BUFS; i++) in_free_mask[i] = (ist[i] == IS_FREE);
    for (int j = 0; j < OUT_BUFS; j++) out_free_mask[j] = (ost[j] == OS_FREE);
  end

  nbc_first_free #(.N(IN_BUFS), .W(IIW)) u_in_pick (
    .mask(in_free_mask), .found(in_has_free), .idx(in_pick));
  nbc_first_free #(.N(OUT_BUFS), .W(OIW)) u_out_pick (
    .mask(out_free_mask), .found(out_has_free), .idx(out_pick));

  assign in_go    = in_req && !in_busy && in_has_free;
  assign in_fin   = in_done && in_busy;
  assign proc_go  = !p_busy && !rdy_empty && out_has_free;
  assign proc_fin = proc_done && p_busy;
  assign out_go   = !o_busy && !pend_empty;
  assign out_fin  = out_done && o_busy;

  nbc_idx_fifo #(.DEPTH(IN_BUFS), .W(IIW)) u_ready_q (
    .clk(clk), .rst(rst), .push(in_fin), .push_idx(in_cur),
    .pop(proc_go), .head(rdy_head), .empty(rdy_empty));
  nbc_idx_fifo #(.DEPTH(OUT_BUFS), .W(OIW)) u_pend_q (
    .clk(clk), .rst(rst), .push(proc_fin), .push_idx(p_out),
    .pop(out_go), .head(pend_head), .empty(pend_empty));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < IN_BUFS; i++) ist[i] <= IS_FREE;
      for (int j = 0; j < OUT_BUFS; j++) ost[j] <= OS_FREE;
      in_busy <= 1'b0;
      p_busy  <= 1'b0;
      o_busy  <= 1'b0;
      in_cur  <= '0;
      p_in    <= '0;
      p_out   <= '0;
      o_cur   <= '0;
      in_start      <= 1'b0;
      proc_start    <= 1'b0;
      out_start     <= 1'b0;
      overflow      <= 1'b0;
      in_start_idx  <= '0;
      proc_in_idx   <= '0;
      proc_out_idx  <= '0;
      out_start_idx <= '0;
    end else begin
      in_start   <= in_go;
      proc_start <= proc_go;
      out_start  <= out_go;
      overflow   <= in_req && !in_go;
      if (in_fin) begin
        ist[in_cur] <= IS_READY;
        in_busy     <= 1'b0;
      end
      if (in_go) begin
        ist[in_pick] <= IS_FILL;
        in_busy      <= 1'b1;
        in_cur       <= in_pick;
        in_start_idx <= in_pick;
      end
      if (proc_go) begin
        ist[rdy_head]  <= IS_WORK;
        ost[out_pick]  <= OS_WRITE;
        p_busy         <= 1'b1;
        p_in           <= rdy_head;
        p_out          <= out_pick;
        proc_in_idx    <= rdy_head;
        proc_out_idx   <= out_pick;
      end
      if (proc_fin) begin
        ist[p_in]  <= IS_FREE;
        ost[p_out] <= OS_PEND;
        p_busy     <= 1'b0;
      end
      if (out_go) begin
        ost[pend_head] <= OS_SEND;
        o_busy         <= 1'b1;
        o_cur          <= pend_head;
        out_start_idx  <= pend_head;
      end
      if (out_fin) begin
        ost[o_cur] <= OS_FREE;
        o_busy     <= 1'b0;
      end
    end
  end

  always_comb begin
    in_free_cnt = '0; in_fill_cnt = '0; in_ready_cnt = '0; in_work_cnt = '0;
    for (int i = 0; i < IN_BUFS; i++) begin
      case (ist[i])
        IS_FREE:  in_free_cnt  = in_free_cnt + ICW'(1);
        IS_FILL:  in_fill_cnt  = in_fill_cnt + ICW'(1);
        IS_READY: in_ready_cnt = in_ready_cnt + ICW'(1);
        default:  in_work_cnt  = in_work_cnt + ICW'(1);
      endcase
    end
  end

  always_comb begin
    out_free_cnt = '0; out_write_cnt = '0; out_pend_cnt = '0; out_send_cnt = '0;
    for (int j = 0; j < OUT_BUFS; j++) begin
      case (ost[j])
        OS_FREE:  out_free_cnt  = out_free_cnt + OCW'(1);
        OS_WRITE: out_write_cnt = out_write_cnt + OCW'(1);
        OS_PEND:  out_pend_cnt  = out_pend_cnt + OCW'(1);
        default:  out_send_cnt  = out_send_cnt + OCW'(1);
      endcase
    end
  end

  // R9: every buffer is in exactly one state
  assert_in_sum_R9: assert property (@(posedge clk) disable iff (rst)
    (32'(in_free_cnt) + 32'(in_fill_cnt) + 32'(in_ready_cnt) + 32'(in_work_cnt)) == IN_BUFS);
  assert_out_sum_R9: assert property (@(posedge clk) disable iff (rst)
    (32'(out_free_cnt) + 32'(out_write_cnt) + 32'(out_pend_cnt) + 32'(out_send_cnt)) == OUT_BUFS);
  // R11: grants are single-cycle pulses
  assert_in_pulse_R11: assert property (@(posedge clk) disable iff (rst) in_start |=> !in_start);
  assert_proc_pulse_R11: assert property (@(posedge clk) disable iff (rst) proc_start |=> !proc_start);
  assert_out_pulse_R11: assert property (@(posedge clk) disable iff (rst) out_start |=> !out_start);
  // R3: a block arriving during a fill is lost
  assert_busy_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (in_req && in_busy) |=> (overflow && !in_start));
  // R5: an idle processor with both buffers available is started
  assert_proc_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (!p_busy && in_ready_cnt != '0 && out_free_cnt != '0) |=> proc_start);
endmodule

// File: tb/test_node_buf_ctrl.sv
module test_node_buf_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 2;
  localparam int NO = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_req = 1'b0, in_done = 1'b0, proc_done = 1'b0, out_done = 1'b0;
  logic in_start, proc_start, out_start, overflow;
  logic [0:0] in_start_idx, proc_in_idx, proc_out_idx, out_start_idx;
  logic [1:0] in_free_cnt, in_fill_cnt, in_ready_cnt, in_work_cnt;
  logic [1:0] out_free_cnt, out_write_cnt, out_pend_cnt, out_send_cnt;

  int checks = 0;
  int errors = 0;
  bit comparing = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  node_buf_ctrl #(.IN_BUFS(NI), .OUT_BUFS(NO)) i_node_buf_ctrl (
    .clk(clk), .rst(rst), .in_req(in_req), .in_done(in_done),
    .proc_done(proc_done), .out_done(out_done),
    .in_start(in_start), .in_start_idx(in_start_idx),
    .proc_start(proc_start), .proc_in_idx(proc_in_idx), .proc_out_idx(proc_out_idx),
    .out_start(out_start), .out_start_idx(out_start_idx), .overflow(overflow),
    .in_free_cnt(in_free_cnt), .in_fill_cnt(in_fill_cnt),
    .in_ready_cnt(in_ready_cnt), .in_work_cnt(in_work_cnt),
    .out_free_cnt(out_free_cnt), .out_write_cnt(out_write_cnt),
    .out_pend_cnt(out_pend_cnt), .out_send_cnt(out_send_cnt));

  // reference model: 0 free, 1 filling/writing, 2 ready/pending, 3 working/sending
  int mi [NI];
  int mo [NO];
  int rq[$];
  int pq[$];
  bit m_ib, m_pb, m_ob;
  int m_icur, m_pin, m_pout, m_ocur;
  bit m_is, m_ps, m_os, m_ovf;
  int m_isi, m_pii, m_poi, m_osi;

  always @(posedge clk) begin
    int fe, oe;
    bit ig, pg, og;
    int hi, ho;
    if (rst) begin
      for (int i = 0; i < NI; i++) mi[i] = 0;
      for (int j = 0; j < NO; j++) mo[j] = 0;
      rq.delete(); pq.delete();
      m_ib = 0; m_pb = 0; m_ob = 0;
      m_is = 0; m_ps = 0; m_os = 0; m_ovf = 0;
    end else begin
      fe = -1; oe = -1;
      for (int i = NI - 1; i >= 0; i--) if (mi[i] == 0) fe = i;
      for (int j = NO - 1; j >= 0; j--) if (mo[j] == 0) oe = j;
      ig = in_req && !m_ib && fe >= 0;
      pg = !m_pb && rq.size() > 0 && oe >= 0;
      og = !m_ob && pq.size() > 0;
      hi = (rq.size() > 0) ? rq[0] : 0;
      ho = (pq.size() > 0) ? pq[0] : 0;
      m_ovf = in_req && !ig;
      m_is = ig; m_ps = pg; m_os = og;
      if (in_done && m_ib) begin mi[m_icur] = 2; rq.push_back(m_icur); m_ib = 0; end
      if (ig) begin mi[fe] = 1; m_ib = 1; m_icur = fe; m_isi = fe; end
      if (pg) begin
        void'(rq.pop_front());
        mi[hi] = 3; mo[oe] = 1; m_pb = 1; m_pin = hi; m_pout = oe; m_pii = hi; m_poi = oe;
      end
      if (proc_done && m_pb) begin mi[m_pin] = 0; mo[m_pout] = 2; pq.push_back(m_pout); m_pb = 0; end
      if (og) begin void'(pq.pop_front()); mo[ho] = 3; m_ob = 1; m_ocur = ho; m_osi = ho; end
      if (out_done && m_ob) begin mo[m_ocur] = 0; m_ob = 0; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mcount(input bit outp, input int st);
    int n = 0;
    if (outp) begin for (int j = 0; j < NO; j++) if (mo[j] == st) n++; end
    else begin for (int i = 0; i < NI; i++) if (mi[i] == st) n++; end
    return n;
  endfunction

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (comparing) begin
      chk("R2 in_start", int'(in_start), int'(m_is));
      if (m_is) chk("R2 in_start_idx", int'(in_start_idx), m_isi);
      chk("R5 proc_start", int'(proc_start), int'(m_ps));
      if (m_ps) begin
        chk("R5 proc_in_idx", int'(proc_in_idx), m_pii);
        chk("R5 proc_out_idx", int'(proc_out_idx), m_poi);
      end
      chk("R7 out_start", int'(out_start), int'(m_os));
      if (m_os) chk("R7 out_start_idx", int'(out_start_idx), m_osi);
      chk("R3 overflow", int'(overflow), int'(m_ovf));
      chk("R9 in_free", int'(in_free_cnt), mcount(0, 0));
      chk("R4 in_fill", int'(in_fill_cnt), mcount(0, 1));
      chk("R4 in_ready", int'(in_ready_cnt), mcount(0, 2));
      chk("R6 in_work", int'(in_work_cnt), mcount(0, 3));
      chk("R9 out_free", int'(out_free_cnt), mcount(1, 0));
      chk("R6 out_write", int'(out_write_cnt), mcount(1, 1));
      chk("R6 out_pend", int'(out_pend_cnt), mcount(1, 2));
      chk("R7 out_send", int'(out_send_cnt), mcount(1, 3));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ti, tp, to, lost;
    bit seen;
    repeat (3) tick();
    // R1: reset state
    chk("R1 in_free", int'(in_free_cnt), NI);
    chk("R1 out_free", int'(out_free_cnt), NO);
    chk("R1 busy counts", int'(in_fill_cnt) + int'(in_ready_cnt) + int'(in_work_cnt)
        + int'(out_write_cnt) + int'(out_pend_cnt) + int'(out_send_cnt), 0);
    chk("R1 pulses", int'(in_start) + int'(proc_start) + int'(out_start) + int'(overflow), 0);
    rst = 1'b0;
    comparing = 1'b1;
    tick();
    // R8: stray done pulses
    in_done = 1; proc_done = 1; out_done = 1;
    tick();
    in_done = 0; proc_done = 0; out_done = 0;
    tick();
    chk("R8 in_free", int'(in_free_cnt), NI);
    chk("R8 out_free", int'(out_free_cnt), NO);
    chk("R8 no grant", int'(in_start) + int'(proc_start) + int'(out_start), 0);
    // single block through the pipeline
    in_req = 1; tick(); in_req = 0;
    chk("R2 grant", int'(in_start), 1);
    chk("R2 idx", int'(in_start_idx), 0);
    chk("R2 filling", int'(in_fill_cnt), 1);
    in_done = 1; tick(); in_done = 0;
    chk("R4 ready", int'(in_ready_cnt), 1);
    tick();
    chk("R5 start", int'(proc_start), 1);
    proc_done = 1; tick(); proc_done = 0;
    chk("R6 in freed", int'(in_free_cnt), NI);
    chk("R6 pending", int'(out_pend_cnt), 1);
    tick();
    chk("R7 send start", int'(out_start), 1);
    out_done = 1; tick(); out_done = 0;
    chk("R7 freed", int'(out_free_cnt), NO);
    // stalled output device: output buffers stay owned
    in_req = 1; tick(); in_req = 0;            // A in0
    in_done = 1; tick(); in_done = 0;
    tick();                                    // A proc out0
    proc_done = 1; tick(); proc_done = 0;      // out0 pending, send starts next
    in_req = 1; tick(); in_req = 0;            // B in0
    in_done = 1; tick(); in_done = 0;
    tick();                                    // B proc out1
    proc_done = 1; tick(); proc_done = 0;
    chk("R7 not freed before send done", int'(out_free_cnt), 0);
    in_req = 1; tick(); in_req = 0;            // C in0
    in_done = 1; tick(); in_done = 0;
    repeat (3) tick();
    chk("R5 waits for output buffer", int'(proc_start), 0);
    chk("R5 ready kept", int'(in_ready_cnt), 1);
    in_req = 1; tick(); in_req = 0;            // D in1
    chk("R2 next free idx", int'(in_start_idx), 1);
    in_req = 1; tick(); in_req = 0;            // request during fill
    chk("R3 busy overflow", int'(overflow), 1);
    in_done = 1; tick(); in_done = 0;
    in_req = 1; tick(); in_req = 0;            // no free input buffer
    chk("R3 full overflow", int'(overflow), 1);
    chk("R3 no grant", int'(in_start), 0);
    chk("R3 counts kept", int'(in_ready_cnt), 2);
    out_done = 1; tick(); out_done = 0;        // out0 done
    chk("R7 free after send", int'(out_free_cnt), 1);
    tick();
    chk("R5 oldest ready", int'(proc_in_idx), 0);
    chk("R5 out idx", int'(proc_out_idx), 0);
    chk("R7 oldest pending", int'(out_start_idx), 1);
    // steady workload with two buffers per pool
    rst = 1; comparing = 0; tick(); tick(); rst = 0; comparing = 1;
    ti = 0; tp = 0; to = 0; lost = 0; seen = 0;
    for (int c = 0; c < 300; c++) begin
      in_req = (c % 6 == 0);
      in_done = (ti == 1); proc_done = (tp == 1); out_done = (to == 1);
      if (ti > 0) ti--;
      if (tp > 0) tp--;
      if (to > 0) to--;
      tick();
      if (in_start) ti = 4;
      if (proc_start) tp = 5;
      if (out_start) to = 4;
      if (in_fill_cnt == 1 && in_work_cnt == 1 && out_send_cnt == 1) seen = 1;
      if (overflow) lost++;
    end
    in_req = 0; in_done = 0; proc_done = 0; out_done = 0;
    chk("R10 overlap", int'(seen), 1);
    chk("R10 no loss", lost, 0);
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule